// File: doc/BRIEF.md
# MMIO Sub-Range Address Router

This block decides, for every 44-bit request address, which path the request takes. It holds two memory-mapped I/O windows: a high window selected by address bits [43:32], and a low window below 4 GB selected by bits [31:24]. Any address that falls in either window normally goes to the default downstream port.

A programmable sub-range can be placed inside one of the two windows. Addresses that hit the sub-range go to the alternate downstream port, which spreads the load across both ports. A separate configuration-space window of 64 MB granularity, above 4 GB, catches configuration accesses. Each such access either targets this node's local registers or is turned into a forwarded non-coherent configuration access.

Software loads all base and limit values through a small register write port. The decision comes out as a registered one-hot route vector with a valid flag, one cycle after the request.

Top module: `mmio_subrange_router`

## Requirements
- R1: After reset, no route is valid and the registers hold these values. The sub-range base, limit and mode are all zero. Both windows are disabled: base all ones, limit zero. The configuration base is zero, which means disabled. Under these values every request is reported as unclaimed.
- R2: A write with `wr_en` high loads the register chosen by `wr_sel`, and the new value takes effect from the next clock onward. A request in the same cycle as the write still sees the old value. The register map is:
  - `wr_sel` = 0: high window, base in data[11:0], limit in data[27:16].
  - `wr_sel` = 1: low window, base in data[7:0], limit in data[15:8].
  - `wr_sel` = 2: sub-range, base in data[7:0], limit in data[15:8], high-mode bit in data[16].
  - `wr_sel` = 3: configuration base in data[17:0].
- R3: The route output is registered.
  - `rt_valid` is high exactly one cycle after `req_valid`.
  - When `rt_valid` is high, exactly one bit of `rt_route` is set: bit0 default port, bit1 alternate port, bit2 local configuration, bit3 forwarded configuration, bit4 unclaimed.
  - When `rt_valid` is low, `rt_route` is zero.
- R4: The high window holds an address when base <= A[43:32] <= limit. It is disabled when its base exceeds its limit.
- R5: The low window holds an address when A[43:32] is zero and base <= A[31:24] <= limit. It is disabled when its base exceeds its limit.
- R6: In high mode, the sub-range compares A[39:32] and requires A[43:40] to be zero. An address hits when sub-base < byte <= sub-limit, because the base field stores one less than the lowest byte.
- R7: In low mode, the sub-range compares A[31:24] and requires A[43:32] to be zero, with the same strict-base rule as R6.
- R8: The sub-range never hits in any of these cases:
  - Its parent window is disabled.
  - The parent window base exceeds the sub-range base.
  - The sub-range limit exceeds the parent window limit.
  - In low mode, the sub-range limit exceeds 0xFD.
- R9: The configuration window is enabled only when its base exceeds 0x03F. An address falls in it when A[43:26] equals the base.
- R10: Inside the configuration window, the request is routed to local configuration when A[25:20] equals `bus_num` and A[19:15] equals `node_id`. Otherwise it is routed to forwarded configuration.
- R11: Routes are chosen in this priority order: configuration window, then sub-range, then either MMIO window (default port), then unclaimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 32 | Register write data |
| node_id | input | 5 | Local node identifier (device number match) |
| bus_num | input | 6 | Local bus number |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 44 | Request address |
| rt_valid | output | 1 | Route result valid |
| rt_route | output | 5 | One-hot route result |

## Verification
A wrong bound register, or a wrong compare sense, shows at the port on the very next cycle. The request that lies exactly on the boundary byte moves from one route bit to a neighbouring one. For that reason, each base and limit is probed one byte inside and one byte outside. A stale or early register update shows up as a wrong route for the request issued in the same cycle as the write. A broken priority shows up as the lower-priority bit being set for an address that sits in overlapping regions.

// File: rtl/mmio_subrange_router.sv
module mmio_subrange_router #(
  parameter int NODE_W = 5,
  parameter int BUS_W  = 6,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NODE_W-1:0] node_id,
  input  logic [BUS_W-1:0]  bus_num,
  input  logic              req_valid,
  input  logic [43:0]       req_addr,
  output logic              rt_valid,
  output logic [4:0]        rt_route
);
  localparam int HW = 12;
  localparam int LW = 8;
  localparam int CW = 18;
  localparam logic [CW-1:0] CFG_MIN = CW'('h3F);
  localparam logic [LW-1:0] LO_CAP  = 8'hFD;

  logic [HW-1:0] hi_base, hi_lim;
  logic [LW-1:0] lo_base, lo_lim;
  logic [LW-1:0] sr_bas, sr_lim;
  logic          sr_hi;
  logic [CW-1:0] cfg_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_base  <= '1;
      hi_lim   <= '0;
      lo_base  <= '1;
      lo_lim   <= '0;
      sr_bas   <= '0;
      sr_lim   <= '0;
      sr_hi    <= 1'b0;
      cfg_base <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: begin
          hi_base <= wr_data[11:0];
          hi_lim  <= wr_data[27:16];
        end
        2'd1: begin
          lo_base <= wr_data[7:0];
          lo_lim  <= wr_data[15:8];
        end
        2'd2: begin
          sr_bas <= wr_data[7:0];
          sr_lim <= wr_data[15:8];
          sr_hi  <= wr_data[16];
        end
        default: cfg_base <= wr_data[CW-1:0];
      endcase
    end
  end

  logic [HW-1:0] a_hi;
  logic [LW-1:0] a_lo, a_mid, sr_byte;
  logic top_clr, below4g, hi_on, lo_on, in_hi, in_lo;
  logic sr_ok_hi, sr_ok_lo, sr_armed, in_sr, in_cfg, cfg_here;
  logic [4:0] route_n;

  assign a_hi    = req_addr[43:32];
  assign a_mid   = req_addr[39:32];
  assign a_lo    = req_addr[31:24];
  assign top_clr = (req_addr[43:40] == 4'h0);
  assign below4g = (a_hi == '0);

  assign hi_on = (hi_base <= hi_lim);
  assign lo_on = (lo_base <= lo_lim);
  assign in_hi = hi_on && (hi_base <= a_hi) && (a_hi <= hi_lim);
  assign in_lo = lo_on && below4g && (lo_base <= a_lo) && (a_lo <= lo_lim);

  assign sr_ok_hi = hi_on && (hi_base <= {4'h0, sr_bas}) && ({4'h0, sr_lim} <= hi_lim);
  assign sr_ok_lo = lo_on && (lo_base <= sr_bas) && (sr_lim <= lo_lim) && (sr_lim <= LO_CAP);
  assign sr_armed = sr_hi ? (sr_ok_hi && top_clr) : (sr_ok_lo && below4g);
  assign sr_byte  = sr_hi ? a_mid : a_lo;
  assign in_sr    = sr_armed && (sr_bas < sr_byte) && (sr_byte <= sr_lim);

  assign in_cfg   = (cfg_base > CFG_MIN) && (req_addr[43:26] == cfg_base);
  assign cfg_here = (req_addr[20 +: BUS_W] == bus_num) && (req_addr[15 +: NODE_W] == node_id);

  always_comb begin
    if (in_cfg)              route_n = cfg_here ? 5'b00100 : 5'b01000;
    else if (in_sr)          route_n = 5'b00010;
    else if (in_hi || in_lo) route_n = 5'b00001;
    else                     route_n = 5'b10000;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rt_valid <= 1'b0;
      rt_route <= '0;
    end else begin
      rt_valid <= req_valid;
      rt_route <= req_valid ? route_n : 5'b00000;
    end
  end
endmodule

// File: rtl/mmio_subrange_router_chk.sv
module mmio_subrange_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [43:0] req_addr,
  input logic        rt_valid,
  input logic [4:0]  rt_route,
  input logic [17:0] cfg_base
);
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid |-> $countones(rt_route) == 1);

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_valid |-> rt_route == 5'b0);

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rt_valid);

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rt_valid);

  a_r6_alt_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && rt_route[1]) |-> ($past(req_addr[43:40]) == 4'h0));

  a_r9_cfg_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && (rt_route[2] || rt_route[3])) |->
      ($past(cfg_base) > 18'h3F && $past(req_addr[43:26]) == $past(cfg_base)));
endmodule

bind mmio_subrange_router mmio_subrange_router_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .rt_valid(rt_valid), .rt_route(rt_route), .cfg_base(cfg_base)
);

// File: tb/mmio_subrange_router_tb.sv
module mmio_subrange_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  node_id = 5'd3;
  logic [5:0]  bus_num = 6'd5;
  logic        req_valid = 1'b0;
  logic [43:0] req_addr = '0;
  logic        rt_valid;
  logic [4:0]  rt_route;

  localparam logic [4:0] DFL = 5'b00001, ALT = 5'b00010, LOC = 5'b00100,
                         FWD = 5'b01000, UNC = 5'b10000;

  int checks = 0;
  int errors = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  mmio_subrange_router dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .node_id(node_id), .bus_num(bus_num), .req_valid(req_valid), .req_addr(req_addr),
    .rt_valid(rt_valid), .rt_route(rt_route)
  );

  always @(negedge clk) begin
    if (rst_n && rt_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected result: actual %b expected none", rt_route);
      end else begin
        automatic logic [4:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rt_route !== e) begin
          errors++;
          $display("FAIL %s: actual %b expected %b", t, rt_route, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic [43:0] a, input logic [4:0] e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr_and_send(input logic [1:0] sel, input logic [31:0] d,
                             input logic [43:0] a, input logic [4:0] e, input string t);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    req_valid = 1'b1; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rt_valid !== 1'b0 || rt_route !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %b/%b expected 0/00000", rt_valid, rt_route);
    end
    send(44'h0, UNC, "R1 zero addr after reset");
    send(44'h1_0000_0000, UNC, "R1 above 4G after reset");

    wr(2'd0, 32'h00FF_0010);
    send(44'h010_0000_0000, DFL, "R4 high base edge");
    send(44'h0FF_FFFF_FFFF, DFL, "R4 high limit edge");
    send(44'h100_0000_0000, UNC, "R4 above high limit");
    send(44'h00F_FFFF_FFFF, UNC, "R4 below high base");

    wr(2'd1, 32'h0000_EF80);
    send(44'h000_8000_0000, DFL, "R5 low base edge");
    send(44'h000_EFFF_FFFF, DFL, "R5 low limit edge");
    send(44'h000_F000_0000, UNC, "R5 above low limit");
    send(44'h000_7FFF_FFFF, UNC, "R5 below low base");
    send(44'h001_8000_0000, UNC, "R5 needs upper bits zero");

    wr_and_send(2'd2, 32'h0001_3020, 44'h021_0000_0000, DFL, "R2 write not yet visible");
    send(44'h020_0000_0000, DFL, "R6 strict base");
    send(44'h021_0000_0000, ALT, "R6 first sub byte");
    send(44'h030_FFFF_FFFF, ALT, "R6 sub limit edge");
    send(44'h031_0000_0000, DFL, "R6 above sub limit");

    wr(2'd0, 32'h00FF_0021);
    send(44'h025_0000_0000, DFL, "R8 window base above sub base");
    wr(2'd0, 32'h002F_0010);
    send(44'h025_0000_0000, DFL, "R8 sub limit beyond window");
    wr(2'd0, 32'h00FF_0100);
    send(44'h025_0000_0000, UNC, "R8 parent disabled");
    wr(2'd0, 32'h00FF_0010);
    send(44'h025_0000_0000, ALT, "R2 restored window");

    wr(2'd2, 32'h0000_A090);
    send(44'h000_9000_0000, DFL, "R7 strict base");
    send(44'h000_9100_0000, ALT, "R7 first sub byte");
    send(44'h000_A0FF_FFFF, ALT, "R7 sub limit edge");
    send(44'h000_A100_0000, DFL, "R7 above sub limit");
    send(44'h091_0000_0000, DFL, "R7 low mode ignores high bits");

    wr(2'd1, 32'h0000_FF80);
    wr(2'd2, 32'h0000_FE90);
    send(44'h000_9100_0000, DFL, "R8 low limit above FD");
    wr(2'd2, 32'h0000_FD90);
    send(44'h000_9100_0000, ALT, "R8 low limit at FD");

    wr(2'd3, 32'h0000_0040);
    send(44'h001_0051_8000, LOC, "R10 local bus and device");
    send(44'h001_0052_0000, FWD, "R10 other device");
    send(44'h001_0061_8000, FWD, "R10 other bus");
    send(44'h001_0400_0000, UNC, "R9 outside cfg window");

    wr(2'd2, 32'h0001_3020);
    wr(2'd3, 32'h0000_0840);
    send(44'h021_0000_0000, FWD, "R11 cfg over sub-range");
    send(44'h021_0400_0000, ALT, "R11 sub-range over window");
    send(44'h040_0000_0000, DFL, "R11 window over unclaimed");

    wr(2'd3, 32'h0000_003F);
    send(44'h000_FC00_0000, DFL, "R9 base 3F disabled");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 results missing: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule